// File: doc/BRIEF.md
# Conversion Result Store with Completion Flags

This block keeps the latest 12-bit result for each of sixteen sample slots. The slots are split evenly between two converters. When a conversion completes, its result is written into the slot's result register. The register's valid bit then sets. If the earlier result was never read, the overrun bit sets as well. Consuming a result clears both bits. On the low slots of each converter, a per-slot enable turns on a second result register. With it on, a slot can hold two unread results before anything is lost.

Every completion is also routed to four completion flags. Each flag has its own 16-bit slot mask. A flag that sets again while it is still pending records a flag overrun. The flags reach the interrupt lines through per-line enables. Software clears flags and flag overruns by writing ones. Aggregate outputs report whether any result is valid, any result has overrun, or any flag has overrun.

The block takes completions from the converter sequencer as a slot number, data and a one-cycle strobe. The bus interface drives the read port and the clear mask.

Top module: `adc_result_buf`

## Requirements
- R1: After reset, every result register, every flag, every flag overrun, every aggregate output and every interrupt line is 0. In particular, `rd_word` reads 0 for every slot.
- R2: `rd_word` shows the register chosen by `rd_slot` and `rd_second`. The layout is: data in bits [11:0], the overrun bit in bit 16, the valid bit in bit 17, and 0 in all other bits. A completion strobe writes `res_data` into that slot, and the new value is visible from the next cycle.
- R3: A cycle with `rd_en` high clears the valid and overrun bits of the register shown on `rd_word`, effective from the next cycle. If a completion lands in that same register in the same cycle, the new result is kept with valid=1 and overrun=0.
- R4: With the second register off, a completion into a slot whose result is still valid replaces the data and sets the overrun bit.
- R5: The second register is usable only on slots 0-3 and 8-11, and only when that slot's bit in `dbuf_en` is 1. In that case the first unread result goes to the primary register and the next goes to the secondary register, with no overrun. A further result, arriving while both registers are still valid, overwrites the secondary register and sets its overrun bit. The primary register is left unchanged.
- R6: A `dbuf_en` bit for any other slot has no effect. That slot behaves as in R4, and its secondary register reads 0.
- R7: `any_valid` is 1 exactly while some register's valid bit is 1. `any_ov` is 1 exactly while some register's overrun bit is 1.
- R8: A completion for slot s sets flag n when bit n*16+s of `src_mask` is 1. Flags whose mask bit is 0 are unchanged.
- R9: `irq[n]` is 1 exactly when `irq_flag[n]` and `int_en[n]` are both 1.
- R10: A flag that is set again while already 1 sets its bit in `flag_ov`. `any_flag_ov` is 1 while any `flag_ov` bit is 1.
- R11: Bits 3:0 of `clr_mask` clear the matching flags, and bits 7:4 clear the matching flag overruns. Zero bits have no effect. If a flag is set and cleared in the same cycle, the set wins and no flag overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Completion strobe, one cycle per result |
| res_slot | input | 4 | Slot of the completed conversion |
| res_data | input | 12 | Conversion result |
| dbuf_en | input | 16 | Per-slot second-register enable (only slots 0-3 and 8-11 honour it) |
| rd_en | input | 1 | Consume the register shown on rd_word |
| rd_second | input | 1 | Select the secondary register for rd_word |
| rd_slot | input | 4 | Slot shown on rd_word |
| rd_word | output | 32 | Selected register: data, overrun bit 16, valid bit 17 |
| src_mask | input | 64 | Per-flag slot masks, flag n in bits n*16+15 : n*16 |
| int_en | input | 4 | Interrupt enables |
| clr_mask | input | 8 | Write-1-to-clear: [3:0] flags, [7:4] flag overruns |
| irq_flag | output | 4 | Completion flags |
| flag_ov | output | 4 | Flag overrun bits |
| irq | output | 4 | Interrupt request lines |
| any_valid | output | 1 | Some result register is valid |
| any_ov | output | 1 | Some result register has overrun |
| any_flag_ov | output | 1 | Some flag has overrun |

## Verification
The properties assume that `res_valid` is a clean strobe whose slot and data are stable at the sampling edge. They also assume that a read cycle touches only the register shown on `rd_word`, so the aggregate valid bit changes only when a completion or a read occurs. The bench drives every input on the falling edge and holds each completion and each read for exactly one cycle. It keeps `res_slot` within the sixteen slots and asserts clear bits only in cycles it has planned. As a result, every flag rise it causes follows a strobe it issued.

// File: rtl/adc_result_buf_pkg.sv
package adc_result_buf_pkg;

   localparam int WORD_W  = 32;
   localparam int OV_BIT  = 16;
   localparam int VLD_BIT = 17;

   // Pack one result register into its visible word
   function automatic logic [WORD_W-1:0] pack_word(input logic [15:0] data,
                                                   input logic        ov,
                                                   input logic        vld);
      logic [WORD_W-1:0] w;
      w          = '0;
      w[15:0]    = data;
      w[OV_BIT]  = ov;
      w[VLD_BIT] = vld;
      return w;
   endfunction

endpackage

// File: rtl/adc_slot_store.sv
module adc_slot_store #(
   parameter int DATA_W = 12,
   parameter bit HAS_SEC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              db_en,
   input  logic              rd_pri,
   input  logic              rd_sec,
   output logic [DATA_W-1:0] pri_data,
   output logic              pri_vld,
   output logic              pri_ov,
   output logic [DATA_W-1:0] sec_data,
   output logic              sec_vld,
   output logic              sec_ov
);

   logic pri_live;
   assign pri_live = pri_vld & ~rd_pri;

   generate
      if (HAS_SEC) begin : g_dual
         logic sec_live;
         logic use_sec;
         assign sec_live = sec_vld & ~rd_sec;
         assign use_sec  = wr & db_en & pri_live;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pri_data <= '0;
               pri_vld  <= 1'b0;
               pri_ov   <= 1'b0;
            end else if (wr && !use_sec) begin
               pri_data <= wdata;
               pri_vld  <= 1'b1;
               pri_ov   <= pri_live;
            end else if (rd_pri) begin
               pri_vld  <= 1'b0;
               pri_ov   <= 1'b0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sec_data <= '0;
               sec_vld  <= 1'b0;
               sec_ov   <= 1'b0;
            end else if (use_sec) begin
               sec_data <= wdata;
               sec_vld  <= 1'b1;
               sec_ov   <= sec_live;
            end else if (rd_sec) begin
               sec_vld  <= 1'b0;
               sec_ov   <= 1'b0;
            end
         end
      end else begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pri_data <= '0;
               pri_vld  <= 1'b0;
               pri_ov   <= 1'b0;
            end else if (wr) begin
               pri_data <= wdata;
               pri_vld  <= 1'b1;
               pri_ov   <= pri_live;
            end else if (rd_pri) begin
               pri_vld  <= 1'b0;
               pri_ov   <= 1'b0;
            end
         end
         assign sec_data = '0;
         assign sec_vld  = 1'b0;
         assign sec_ov   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adc_flag_cell.sv
module adc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr_flag,
   input  logic clr_ov,
   input  logic en,
   output logic flag,
   output logic ov,
   output logic req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         ov   <= 1'b0;
      end else begin
         flag <= hit | (flag & ~clr_flag);
         ov   <= (ov & ~clr_ov) | (hit & flag & ~clr_flag);
      end
   end

   assign req = flag & en;

endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
   parameter int NUM_SLOTS      = 16,
   parameter int SLOTS_PER_CONV = 8,
   parameter int DB_PER_CONV    = 4,
   parameter int DATA_W         = 12,
   parameter int NUM_IRQ        = 4,
   localparam int SLOT_W        = $clog2(NUM_SLOTS),
   localparam int WORD_W        = adc_result_buf_pkg::WORD_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         res_valid,
   input  logic [SLOT_W-1:0]            res_slot,
   input  logic [DATA_W-1:0]            res_data,
   input  logic [NUM_SLOTS-1:0]         dbuf_en,
   input  logic                         rd_en,
   input  logic                         rd_second,
   input  logic [SLOT_W-1:0]            rd_slot,
   output logic [WORD_W-1:0]            rd_word,
   input  logic [NUM_IRQ*NUM_SLOTS-1:0] src_mask,
   input  logic [NUM_IRQ-1:0]           int_en,
   input  logic [2*NUM_IRQ-1:0]         clr_mask,
   output logic [NUM_IRQ-1:0]           irq_flag,
   output logic [NUM_IRQ-1:0]           flag_ov,
   output logic [NUM_IRQ-1:0]           irq,
   output logic                         any_valid,
   output logic                         any_ov,
   output logic                         any_flag_ov
);
   import adc_result_buf_pkg::*;

   generate
      if (NUM_SLOTS % SLOTS_PER_CONV != 0) begin : g_bad_split
         $error("NUM_SLOTS must be a multiple of SLOTS_PER_CONV");
      end
      if (DB_PER_CONV > SLOTS_PER_CONV) begin : g_bad_db
         $error("DB_PER_CONV exceeds SLOTS_PER_CONV");
      end
      if (DATA_W > 16 || DATA_W < 1) begin : g_bad_width
         $error("DATA_W must lie in 1..16");
      end
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("NUM_IRQ must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]    p_data [NUM_SLOTS];
   logic [DATA_W-1:0]    s_data [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] p_vld, p_ov, s_vld, s_ov;
   logic [NUM_SLOTS-1:0] wr_hot, rd_hot;

   always_comb begin
      wr_hot = '0;
      rd_hot = '0;
      if (res_valid) wr_hot[res_slot] = 1'b1;
      if (rd_en)     rd_hot[rd_slot]  = 1'b1;
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam bit SEC_OK = (s % SLOTS_PER_CONV) < DB_PER_CONV;
      adc_slot_store #(.DATA_W(DATA_W), .HAS_SEC(SEC_OK)) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_hot[s]),
         .wdata    (res_data),
         .db_en    (dbuf_en[s]),
         .rd_pri   (rd_hot[s] & ~rd_second),
         .rd_sec   (rd_hot[s] & rd_second),
         .pri_data (p_data[s]),
         .pri_vld  (p_vld[s]),
         .pri_ov   (p_ov[s]),
         .sec_data (s_data[s]),
         .sec_vld  (s_vld[s]),
         .sec_ov   (s_ov[s])
      );
   end

   // Visible word of the addressed register (peek does not consume)
   always_comb begin
      logic [15:0] d;
      d = '0;
      if (rd_second) begin
         d[DATA_W-1:0] = s_data[rd_slot];
         rd_word = pack_word(d, s_ov[rd_slot], s_vld[rd_slot]);
      end else begin
         d[DATA_W-1:0] = p_data[rd_slot];
         rd_word = pack_word(d, p_ov[rd_slot], p_vld[rd_slot]);
      end
   end

   assign any_valid = |(p_vld | s_vld);
   assign any_ov    = |(p_ov | s_ov);

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_flag
      logic hit;
      assign hit = res_valid & src_mask[n*NUM_SLOTS + res_slot];
      adc_flag_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (hit),
         .clr_flag (clr_mask[n]),
         .clr_ov   (clr_mask[NUM_IRQ+n]),
         .en       (int_en[n]),
         .flag     (irq_flag[n]),
         .ov       (flag_ov[n]),
         .req      (irq[n])
      );
   end

   assign any_flag_ov = |flag_ov;

endmodule

// File: rtl/adc_result_buf_chk.sv
module adc_result_buf_chk #(
   parameter int NUM_IRQ = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               res_valid,
   input logic               rd_en,
   input logic [NUM_IRQ-1:0] irq_flag,
   input logic [NUM_IRQ-1:0] flag_ov,
   input logic               any_valid,
   input logic               any_ov
);

   // R2
   capture_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> any_valid);

   // R7
   ov_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_ov |-> any_valid);

   // R7
   valid_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && !rd_en) |=> $stable(any_valid));

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq_chk
      // R8
      flag_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_flag[n]) |-> $past(res_valid));

      // R10
      fov_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_ov[n]) |-> ($past(irq_flag[n]) && $past(res_valid)));
   end

endmodule

bind adc_result_buf adc_result_buf_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_valid (res_valid),
   .rd_en     (rd_en),
   .irq_flag  (irq_flag),
   .flag_ov   (flag_ov),
   .any_valid (any_valid),
   .any_ov    (any_ov)
);

// File: tb/adc_result_buf_bench.sv
`timescale 1ns/100ps
module adc_result_buf_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [3:0]  res_slot = '0;
   logic [11:0] res_data = '0;
   logic [15:0] dbuf_en = '0;
   logic        rd_en = 1'b0;
   logic        rd_second = 1'b0;
   logic [3:0]  rd_slot = '0;
   logic [31:0] rd_word;
   logic [63:0] src_mask = '0;
   logic [3:0]  int_en = '0;
   logic [7:0]  clr_mask = '0;
   logic [3:0]  irq_flag, flag_ov, irq;
   logic        any_valid, any_ov, any_flag_ov;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   adc_result_buf u_adc_result_buf (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
      .res_data(res_data), .dbuf_en(dbuf_en), .rd_en(rd_en), .rd_second(rd_second),
      .rd_slot(rd_slot), .rd_word(rd_word), .src_mask(src_mask), .int_en(int_en),
      .clr_mask(clr_mask), .irq_flag(irq_flag), .flag_ov(flag_ov), .irq(irq),
      .any_valid(any_valid), .any_ov(any_ov), .any_flag_ov(any_flag_ov)
   );

   // slot, first data, second data, two writes, expected primary word
   localparam logic [60:0] TBL [8] = '{
      {4'd0,  12'h123, 12'h000, 1'b0, 32'h0002_0123},
      {4'd15, 12'hFFF, 12'h000, 1'b0, 32'h0002_0FFF},
      {4'd7,  12'h001, 12'h800, 1'b1, 32'h0003_0800},
      {4'd9,  12'h0AA, 12'h000, 1'b0, 32'h0002_00AA},
      {4'd4,  12'h555, 12'h2AA, 1'b1, 32'h0003_02AA},
      {4'd12, 12'h000, 12'h000, 1'b0, 32'h0002_0000},
      {4'd1,  12'h7FE, 12'h7FF, 1'b1, 32'h0003_07FF},
      {4'd10, 12'hC3C, 12'h000, 1'b0, 32'h0002_0C3C}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [3:0] slot, input logic [11:0] d);
      @(negedge clk);
      res_valid = 1'b1; res_slot = slot; res_data = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   // peek then consume in one cycle
   task automatic take(input logic [3:0] slot, input logic sec, output logic [31:0] w);
      @(negedge clk);
      rd_slot = slot; rd_second = sec; rd_en = 1'b1;
      #1 w = rd_word;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [3:0] slot, input logic sec, output logic [31:0] w);
      @(negedge clk);
      rd_slot = slot; rd_second = sec;
      #1 w = rd_word;
   endtask

   task automatic clear(input logic [7:0] m);
      @(negedge clk);
      clr_mask = m;
      @(negedge clk);
      clr_mask = '0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(4'd3, 1'b0, w);  check("R1 rd_word pri", w, 32'h0);
      peek(4'd3, 1'b1, w);  check("R1 rd_word sec", w, 32'h0);
      check("R1 status", {24'h0, irq_flag, flag_ov}, 32'h0);
      check("R1 aggregates", {28'h0, irq, any_valid, any_ov, any_flag_ov} , 32'h0);

      // R2 R3 R4 table walk
      for (int i = 0; i < 8; i++) begin
         put(TBL[i][60:57], TBL[i][56:45]);
         if (TBL[i][32]) put(TBL[i][60:57], TBL[i][44:33]);
         take(TBL[i][60:57], 1'b0, w);
         check(TBL[i][32] ? "R4 overwrite" : "R2 capture", w, TBL[i][31:0]);
         peek(TBL[i][60:57], 1'b0, w);
         check("R3 read clears", w, {14'h0, 2'b00, 4'h0, TBL[i][31:0] == 32'h0 ? 12'h0 : w[11:0]});
      end
      check("R7 none valid", {31'h0, any_valid}, 32'h0);

      // R5 double buffer on slot 2
      dbuf_en = 16'h0024;
      put(4'd2, 12'h111);
      put(4'd2, 12'h222);
      check("R7 no ov with two", {31'h0, any_ov}, 32'h0);
      take(4'd2, 1'b0, w); check("R5 primary", w, 32'h0002_0111);
      take(4'd2, 1'b1, w); check("R5 secondary", w, 32'h0002_0222);
      put(4'd2, 12'h333);
      put(4'd2, 12'h444);
      put(4'd2, 12'h555);
      check("R7 any_ov", {30'h0, any_valid, any_ov}, 32'h3);
      take(4'd2, 1'b1, w); check("R5 secondary overrun", w, 32'h0003_0555);
      take(4'd2, 1'b0, w); check("R5 primary kept", w, 32'h0002_0333);

      // R6 dbuf_en on slot 5 ignored
      put(4'd5, 12'h0A1);
      put(4'd5, 12'h0A2);
      peek(4'd5, 1'b1, w); check("R6 no secondary", w, 32'h0);
      take(4'd5, 1'b0, w); check("R6 single overrun", w, 32'h0003_00A2);
      dbuf_en = '0;

      // R3 read and write in one cycle
      put(4'd6, 12'h100);
      @(negedge clk);
      rd_slot = 4'd6; rd_second = 1'b0; rd_en = 1'b1;
      res_valid = 1'b1; res_slot = 4'd6; res_data = 12'h200;
      @(negedge clk);
      rd_en = 1'b0; res_valid = 1'b0;
      take(4'd6, 1'b0, w); check("R3 same cycle", w, 32'h0002_0200);
      check("R7 drained", {30'h0, any_valid, any_ov}, 32'h0);

      // R8 R9 R10 R11 flag routing
      src_mask = 64'h0000_0000_0008_0000;   // flag 1 <- slot 3
      put(4'd4, 12'h001);
      check("R8 unmasked slot", {28'h0, irq_flag}, 32'h0);
      put(4'd3, 12'h002);
      check("R8 flag set", {28'h0, irq_flag}, 32'h2);
      check("R9 disabled", {28'h0, irq}, 32'h0);
      int_en = 4'b0010;
      #1 check("R9 enabled", {28'h0, irq}, 32'h2);
      put(4'd3, 12'h003);
      check("R10 flag overrun", {27'h0, any_flag_ov, flag_ov}, 32'h12);
      clear(8'h02);
      check("R11 flag cleared", {24'h0, flag_ov, irq_flag}, 32'h20);
      check("R9 irq drop", {28'h0, irq}, 32'h0);
      clear(8'h20);
      check("R11 fov cleared", {27'h0, any_flag_ov, flag_ov}, 32'h0);
      put(4'd3, 12'h004);
      @(negedge clk);
      clr_mask = 8'h02; res_valid = 1'b1; res_slot = 4'd3; res_data = 12'h005;
      @(negedge clk);
      clr_mask = '0; res_valid = 1'b0;
      check("R11 set wins", {24'h0, flag_ov, irq_flag}, 32'h02);
      clear(8'h00);
      check("R11 zero mask", {28'h0, irq_flag}, 32'h2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule